// File: doc/BRIEF.md
# Serial Channel Mode Router

This block sits between a serial port's CPU data register, its receive FIFO write port, its transmit serializer and its line deserializer. It steers each character according to a 2-bit channel mode. The four modes are normal, automatic echo, local loopback and remote loopback. Both paths are gated by the port's control register. Each path is active only when its enable bit is set and its disable bit is clear.

The control register lives here as well. Its two reset bits produce one-cycle flush pulses for the receive and transmit paths and then clear themselves. The transmit side has a one-byte output slot with a valid/ready handshake and a one-byte echo holding register. Line characters echoed back out take priority over CPU writes. The CPU data write is held off through a ready signal while an echo byte waits. Serialization and FIFO storage are outside the block.

Top module: `chroute_mode_router`

## Requirements
- R1: After reset the control value reads 0x128: RX disable (bit 3) and TX disable (bit 5) are set and both paths are inactive; no flush pulse, no FIFO write and no transmit byte is presented, and `cpu_wr_ready` is 1.
- R2: A path is active only when its enable bit is set and its disable bit is clear (RX enable bit 2, RX disable bit 3, TX enable bit 4, TX disable bit 5); the disable bit wins when both are set.
- R3: With RX active and `chan_mode` 0 (normal) or 1 (echo), a line character pulses `rxf_wr_valid` with that byte in the cycle after it is sampled; in modes 2 (local loopback) and 3 (remote loopback) line characters never reach the FIFO.
- R4: A line break in modes 0 or 1 with RX active writes the byte 0x00 to the FIFO, even if a data character is flagged in the same cycle.
- R5: With TX active and mode 1 or 3, a line character is also offered on the transmit path; in modes 0 and 2 it is not.
- R6: A CPU data write goes to the transmit path in mode 0 (when TX is active) and to the FIFO in mode 2 (when RX is active); in modes 1 and 3 it is accepted with `cpu_wr_ready` high and discarded.
- R7: Writing control bit 0 (RX reset) raises `rx_flush` for exactly the cycle after the write, and bit 0 then reads 0.
- R8: Writing control bit 1 (TX reset) raises `tx_flush` for exactly the cycle after the write, bit 1 then reads 0, and any held transmit byte and pending echo byte are discarded.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R10: A pending echo byte is sent before any CPU byte, and while it waits (or while the slot is busy in normal mode) `cpu_wr_ready` is low.
- R11: An echo character that arrives while the slot is busy and an echo byte is already pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write value |
| ctrl_value | output | 9 | Current control register value |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| cpu_wr_valid | input | 1 | CPU data register write |
| cpu_wr_data | input | 8 | CPU data byte |
| cpu_wr_ready | output | 1 | CPU write accepted this cycle |
| line_rx_valid | input | 1 | Character received from the line |
| line_rx_break | input | 1 | Break received from the line |
| line_rx_data | input | 8 | Received character |
| rxf_wr_valid | output | 1 | Receive FIFO write strobe |
| rxf_wr_data | output | 8 | Receive FIFO write byte |
| rx_flush | output | 1 | Receive path reset pulse |
| tx_valid | output | 1 | Transmit byte presented |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer takes the presented byte |
| tx_flush | output | 1 | Transmit path reset pulse |

## Verification
A routing error shows at the ports one cycle after the character is sampled: the byte appears on the wrong strobe, or it appears on none. A reset bit that fails to clear shows as a flush pulse lasting two or more cycles. A stale echo-pending flag shows as `cpu_wr_ready` stuck low in normal mode, or as an extra byte on `tx_data` once `tx_ready` rises. The bench checks the echo, drop and CPU ordering on the transmit side byte by byte.

// File: rtl/chroute_pkg.sv
package chroute_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CB_RX_RST = 0;
  localparam int CB_TX_RST = 1;
  localparam int CB_RX_EN  = 2;
  localparam int CB_RX_DIS = 3;
  localparam int CB_TX_EN  = 4;
  localparam int CB_TX_DIS = 5;

  function automatic logic path_on(input logic en, input logic dis);
    return en & ~dis;
  endfunction

  function automatic logic line_goes_fifo(input logic [1:0] m);
    return (m == CM_NORMAL) || (m == CM_ECHO);
  endfunction

  function automatic logic line_goes_tx(input logic [1:0] m);
    return (m == CM_ECHO) || (m == CM_REMOTE);
  endfunction

  function automatic logic cpu_goes_tx(input logic [1:0] m);
    return m == CM_NORMAL;
  endfunction

  function automatic logic cpu_goes_fifo(input logic [1:0] m);
    return m == CM_LOCAL;
  endfunction

endpackage

// File: rtl/chroute_ctrl.sv
module chroute_ctrl
  import chroute_pkg::*;
#(
  parameter int                 CTRL_W    = 9,
  parameter logic [CTRL_W-1:0]  CTRL_INIT = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              rx_active,
  output logic              tx_active,
  output logic              rx_flush,
  output logic              tx_flush
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (wr) begin
      ctrl_q <= wdata;
    end else begin
      ctrl_q[CB_RX_RST] <= 1'b0;
      ctrl_q[CB_TX_RST] <= 1'b0;
    end
  end

  assign rx_active = path_on(ctrl_q[CB_RX_EN], ctrl_q[CB_RX_DIS]);
  assign tx_active = path_on(ctrl_q[CB_TX_EN], ctrl_q[CB_TX_DIS]);
  assign rx_flush  = ctrl_q[CB_RX_RST];
  assign tx_flush  = ctrl_q[CB_TX_RST];

  // R1
  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == CTRL_INIT));
  // R7
  a_r7_rx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush && !wr |=> !rx_flush);
  // R8
  a_r8_tx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush && !wr |=> !tx_flush);

endmodule

// File: rtl/chroute_rx.sv
module chroute_rx
  import chroute_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              rx_active,
  input  logic              line_valid,
  input  logic              line_break,
  input  logic [DATA_W-1:0] line_data,
  input  logic              cpu_valid,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);

  logic              take_line;
  logic              take_brk;
  logic              take_cpu;
  logic [DATA_W-1:0] next_byte;

  always_comb begin
    take_brk  = rx_active && line_goes_fifo(mode) && line_break;
    take_line = rx_active && line_goes_fifo(mode) && line_valid;
    take_cpu  = rx_active && cpu_goes_fifo(mode) && cpu_valid;
    if (take_brk)       next_byte = '0;
    else if (take_line) next_byte = line_data;
    else                next_byte = cpu_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= take_brk | take_line | take_cpu;
      if (take_brk | take_line | take_cpu) wr_data <= next_byte;
    end
  end

  // R4
  a_r4_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    take_brk |=> wr_valid && (wr_data == '0));
  // R2
  a_r2_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(rx_active));

endmodule

// File: rtl/chroute_tx.sv
module chroute_tx
  import chroute_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              tx_active,
  input  logic              flush,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  input  logic              cpu_valid,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              cpu_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  logic              pend_q;
  logic [DATA_W-1:0] pend_d;
  logic              echo_in;
  logic              cpu_path;
  logic              slot_free;
  logic              cpu_take;

  always_comb begin
    echo_in   = tx_active && line_goes_tx(mode) && line_valid;
    cpu_path  = tx_active && cpu_goes_tx(mode);
    slot_free = !out_valid || out_ready;
    cpu_ready = cpu_path ? (!flush && slot_free && !pend_q) : 1'b1;
    cpu_take  = cpu_path && cpu_valid && cpu_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      pend_q    <= 1'b0;
      pend_d    <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
      pend_q    <= 1'b0;
    end else if (slot_free) begin
      if (pend_q) begin
        out_valid <= 1'b1;
        out_data  <= pend_d;
        pend_q    <= echo_in;
        if (echo_in) pend_d <= line_data;
      end else if (echo_in) begin
        out_valid <= 1'b1;
        out_data  <= line_data;
      end else if (cpu_take) begin
        out_valid <= 1'b1;
        out_data  <= cpu_data;
      end else begin
        out_valid <= 1'b0;
      end
    end else if (echo_in && !pend_q) begin
      pend_q <= 1'b1;
      pend_d <= line_data;
    end
  end

  // R9
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data));
  // R10
  a_r10_echo_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && slot_free && !flush |=> out_valid && (out_data == $past(pend_d)));
  // R8
  a_r8_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !pend_q);

endmodule

// File: rtl/chroute_mode_router.sv
module chroute_mode_router
  import chroute_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                CTRL_W    = 9,
  parameter logic [CTRL_W-1:0] CTRL_INIT = 9'h128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_value,
  input  logic [1:0]        chan_mode,
  input  logic              cpu_wr_valid,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              cpu_wr_ready,
  input  logic              line_rx_valid,
  input  logic              line_rx_break,
  input  logic [DATA_W-1:0] line_rx_data,
  output logic              rxf_wr_valid,
  output logic [DATA_W-1:0] rxf_wr_data,
  output logic              rx_flush,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              tx_flush
);

  logic rx_active;
  logic tx_active;

  chroute_ctrl #(.CTRL_W(CTRL_W), .CTRL_INIT(CTRL_INIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .wdata    (ctrl_wdata),
    .ctrl_q   (ctrl_value),
    .rx_active(rx_active),
    .tx_active(tx_active),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  chroute_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (chan_mode),
    .rx_active (rx_active),
    .line_valid(line_rx_valid),
    .line_break(line_rx_break),
    .line_data (line_rx_data),
    .cpu_valid (cpu_wr_valid),
    .cpu_data  (cpu_wr_data),
    .wr_valid  (rxf_wr_valid),
    .wr_data   (rxf_wr_data)
  );

  chroute_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (chan_mode),
    .tx_active (tx_active),
    .flush     (tx_flush),
    .line_valid(line_rx_valid),
    .line_data (line_rx_data),
    .cpu_valid (cpu_wr_valid),
    .cpu_data  (cpu_wr_data),
    .cpu_ready (cpu_wr_ready),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready)
  );

  // R6
  a_r6_discard_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_valid && line_goes_tx(chan_mode) |-> cpu_wr_ready);
  // R3
  a_r3_no_line_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    line_rx_valid && !line_rx_break && !cpu_wr_valid && !line_goes_fifo(chan_mode)
    |=> !rxf_wr_valid);

endmodule

// File: tb/chroute_mode_router_bench.sv
module chroute_mode_router_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [8:0] ctrl_wdata = '0;
  logic [8:0] ctrl_value;
  logic [1:0] chan_mode = 2'd0;
  logic       cpu_wr_valid = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic       cpu_wr_ready;
  logic       line_rx_valid = 1'b0;
  logic       line_rx_break = 1'b0;
  logic [7:0] line_rx_data = '0;
  logic       rxf_wr_valid;
  logic [7:0] rxf_wr_data;
  logic       rx_flush;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b1;
  logic       tx_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroute_mode_router u_chroute_mode_router (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_value(ctrl_value), .chan_mode(chan_mode), .cpu_wr_valid(cpu_wr_valid),
    .cpu_wr_data(cpu_wr_data), .cpu_wr_ready(cpu_wr_ready),
    .line_rx_valid(line_rx_valid), .line_rx_break(line_rx_break),
    .line_rx_data(line_rx_data), .rxf_wr_valid(rxf_wr_valid),
    .rxf_wr_data(rxf_wr_data), .rx_flush(rx_flush), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_flush(tx_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_ctrl(input logic [8:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    step();
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", int'(ctrl_value), 'h128);
    chk("R1 flush", int'({rx_flush, tx_flush}), 0);
    chk("R1 rxf", int'(rxf_wr_valid), 0);
    chk("R1 tx", int'(tx_valid), 0);
    chk("R1 ready", int'(cpu_wr_ready), 1);
  endtask

  task automatic t_gating();
    set_ctrl(9'h00C);                                // RX en+dis, TX off
    line_rx_valid = 1'b1; line_rx_data = 8'h3C;
    step();
    chk("R2 rx disable wins", int'(rxf_wr_valid), 0);
    set_ctrl(9'h034);                                // RX on, TX en+dis
    line_rx_valid = 1'b0; cpu_wr_valid = 1'b1; cpu_wr_data = 8'h77;
    #1 chk("R2 gated cpu ready", int'(cpu_wr_ready), 1);
    step();
    chk("R2 tx disable wins", int'(tx_valid), 0);
    @(negedge clk); cpu_wr_valid = 1'b0; line_rx_valid = 1'b1; line_rx_data = 8'h42;
    step();
    chk("R2 rx enabled", int'(rxf_wr_valid), 1);
    chk("R2 rx data", int'(rxf_wr_data), 'h42);
    @(negedge clk); line_rx_valid = 1'b0;
  endtask

  task automatic t_line_modes();
    set_ctrl(9'h014);
    tx_ready = 1'b1;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); chan_mode = 2'(m);
      line_rx_valid = 1'b1; line_rx_data = 8'(8'h10 + m);
      step();
      chk("R3 fifo strobe", int'(rxf_wr_valid), (m < 2) ? 1 : 0);
      if (m < 2) chk("R3 fifo byte", int'(rxf_wr_data), 'h10 + m);
      chk("R5 tx strobe", int'(tx_valid), (m == 1 || m == 3) ? 1 : 0);
      if (m == 1 || m == 3) chk("R5 tx byte", int'(tx_data), 'h10 + m);
      @(negedge clk); line_rx_valid = 1'b0;
      step();
    end
  endtask

  task automatic t_cpu_modes();
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); chan_mode = 2'(m);
      cpu_wr_valid = 1'b1; cpu_wr_data = 8'(8'h60 + m);
      #1 chk("R6 ready", int'(cpu_wr_ready), 1);
      step();
      chk("R6 to tx", int'(tx_valid), (m == 0) ? 1 : 0);
      if (m == 0) chk("R6 tx byte", int'(tx_data), 'h60);
      chk("R6 to fifo", int'(rxf_wr_valid), (m == 2) ? 1 : 0);
      if (m == 2) chk("R6 fifo byte", int'(rxf_wr_data), 'h62);
      @(negedge clk); cpu_wr_valid = 1'b0;
      step();
    end
  endtask

  task automatic t_break();
    @(negedge clk); chan_mode = 2'd0;
    line_rx_break = 1'b1; line_rx_valid = 1'b1; line_rx_data = 8'h55;
    step();
    chk("R4 break write", int'(rxf_wr_valid), 1);
    chk("R4 break zero", int'(rxf_wr_data), 0);
    @(negedge clk); chan_mode = 2'd2; line_rx_valid = 1'b0;
    step();
    chk("R4 break local ignored", int'(rxf_wr_valid), 0);
    @(negedge clk); line_rx_break = 1'b0; chan_mode = 2'd0;
    step();
  endtask

  task automatic t_reset_bits();
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 9'h015;
    step();
    chk("R7 rx pulse", int'(rx_flush), 1);
    @(negedge clk); ctrl_wr = 1'b0;
    step();
    chk("R7 rx pulse ends", int'(rx_flush), 0);
    chk("R7 bit clears", int'(ctrl_value), 'h014);
    // hold a byte, then flush the transmit path
    @(negedge clk); tx_ready = 1'b0; chan_mode = 2'd0;
    cpu_wr_valid = 1'b1; cpu_wr_data = 8'hE0;
    step();
    chk("R8 byte held", int'(tx_valid), 1);
    @(negedge clk); cpu_wr_valid = 1'b0; ctrl_wr = 1'b1; ctrl_wdata = 9'h016;
    step();
    chk("R8 tx pulse", int'(tx_flush), 1);
    @(negedge clk); ctrl_wr = 1'b0;
    step();
    chk("R8 byte dropped", int'(tx_valid), 0);
    chk("R8 pulse ends", int'(tx_flush), 0);
    chk("R8 bit clears", int'(ctrl_value), 'h014);
  endtask

  task automatic t_hold();
    @(negedge clk); tx_ready = 1'b0; chan_mode = 2'd0;
    cpu_wr_valid = 1'b1; cpu_wr_data = 8'hA1;
    step();
    chk("R9 first byte", int'(tx_data), 'hA1);
    @(negedge clk); cpu_wr_data = 8'hA2;
    #1 chk("R10 busy slot ready", int'(cpu_wr_ready), 0);
    step(); step(); step();
    chk("R9 valid held", int'(tx_valid), 1);
    chk("R9 data held", int'(tx_data), 'hA1);
    @(negedge clk); tx_ready = 1'b1;
    step();
    chk("R9 next byte", int'(tx_data), 'hA2);
    @(negedge clk); cpu_wr_valid = 1'b0;
    step();
    chk("R9 drained", int'(tx_valid), 0);
  endtask

  task automatic t_echo_priority();
    @(negedge clk); tx_ready = 1'b0; chan_mode = 2'd1;
    line_rx_valid = 1'b1; line_rx_data = 8'hB0;
    step();
    chk("R5 echo direct", int'(tx_data), 'hB0);
    chk("R3 echo to fifo", int'(rxf_wr_data), 'hB0);
    @(negedge clk); line_rx_data = 8'hB1;
    step();
    @(negedge clk); line_rx_data = 8'hB2;
    step();
    @(negedge clk); line_rx_valid = 1'b0; chan_mode = 2'd0;
    cpu_wr_valid = 1'b1; cpu_wr_data = 8'hD0;
    #1 chk("R10 cpu held off", int'(cpu_wr_ready), 0);
    step();
    chk("R9 echo byte held", int'(tx_data), 'hB0);
    @(negedge clk); tx_ready = 1'b1;
    #1 chk("R10 held while pending", int'(cpu_wr_ready), 0);
    step();
    chk("R10 pending echo first", int'(tx_data), 'hB1);
    chk("R10 cpu now ready", int'(cpu_wr_ready), 1);
    step();
    chk("R11 third echo dropped", int'(tx_data), 'hD0);
    @(negedge clk); cpu_wr_valid = 1'b0;
    step();
    chk("R11 nothing left", int'(tx_valid), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    step();
    t_gating();
    t_line_modes();
    t_cpu_modes();
    t_break();
    t_reset_bits();
    t_hold();
    t_echo_priority();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule